// File: doc/BRIEF.md
# Serial-Programmed Video Crosspoint Routing Controller

This block holds the routing state of an 8-source, 6-destination video crosspoint. An analog switch fabric sits outside it. The block is a write-only two-wire serial slave. A host addresses it with one byte and then sends one or more routing bytes. Each routing byte names one destination and the source that destination should carry. The block keeps a 3-bit source select for each destination and drives it to the fabric. It also drives a flag for each destination, which shows that the select has been programmed since reset. Before that the select has no meaning.

A static strap input picks one of two slave addresses, so two instances can share one bus and together double the number of switch points. In a routing byte the upper five bits name the destination through a fixed, non-sequential code table. The lower three bits name the source. A routing byte with a destination code outside the table is acknowledged and then discarded. One source may feed any number of destinations, and each destination carries exactly one source.

Top module: `vidx_route_ctrl`

## Requirements
- R1: After reset every destination-valid flag is 0 and the slave does not pull the data line low.
- R2: The slave acknowledges the address byte 0x86 when the strap is 0 and 0x06 when the strap is 1. It acknowledges no other address byte, including the same value with bit 0 set. After a byte it does not acknowledge, it neither acknowledges nor applies any byte until the next START.
- R3: The destination code in routing-byte bits [7:3] maps as follows: 00000 to destination 0, 00100 to 1, 00010 to 2, 00001 to 3, 00101 to 4, 00011 to 5. The byte 0x25 routes source 5 to destination 1.
- R4: Routing-byte bits [2:0] are copied unchanged into the addressed destination's select, which appears on `sel_o[3*d+2:3*d]`. All eight values are accepted.
- R5: A routing byte changes the select of at most one destination. Every other select and flag keeps its value.
- R6: A destination's valid flag sets on its first routing byte and stays set until reset.
- R7: A routing byte whose bits [7:3] match no code in R3 is acknowledged, and no select or flag changes.
- R8: Several routing bytes in one transaction are applied in order, each acknowledged. Each takes effect at the rising clock edge of its acknowledge bit, before the transaction ends. A later byte for the same destination overrides an earlier one.
- R9: The acknowledge is driven from a falling SCL edge while SCL is low. It is held through the ninth clock pulse and released after the falling edge of that pulse.
- R10: A START seen in any state, including partway through a byte, restarts address reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock from the bus, asynchronous |
| sda_i | input | 1 | Serial data from the bus, asynchronous |
| strap_i | input | 1 | Static address strap: 0 selects 0x86, 1 selects 0x06 |
| sda_oe_o | output | 1 | 1 pulls the data line low (acknowledge) |
| sel_o | output | 18 | Source select for each destination, 3 bits each, destination 0 in the low bits |
| valid_o | output | 6 | Per-destination programmed flag |

## Verification
The assertions assume that the two bus lines, once synchronised, change apart from each other. Data may change only while the clock is low. The one exception is a START or STOP, where data changes while the clock is held high. They also assume the strap changes only while the bus is idle. The stimulus keeps within these limits: each clock phase lasts ten system cycles, and data moves four cycles after a falling edge, which is well past the synchroniser delay. Every START and STOP holds the clock high for a full phase. The strap is changed only between transactions.

// File: rtl/vxr_pkg.sv
package vxr_pkg;

  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_ADDR = 2'd1,
    RX_DATA = 2'd2,
    RX_SKIP = 2'd3
  } rx_state_t;

  typedef struct packed {
    logic       hit;
    logic [2:0] idx;
  } dst_dec_t;

  // Destination code (routing byte [7:3]) to destination index.
  function automatic dst_dec_t decode_dst(input logic [4:0] code);
    dst_dec_t d;
    d.hit = 1'b1;
    d.idx = 3'd0;
    case (code)
      5'b00000: d.idx = 3'd0;
      5'b00100: d.idx = 3'd1;
      5'b00010: d.idx = 3'd2;
      5'b00001: d.idx = 3'd3;
      5'b00101: d.idx = 3'd4;
      5'b00011: d.idx = 3'd5;
      default:  d.hit = 1'b0;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/vxr_sync.sv
module vxr_sync #(
  parameter int         W       = 2,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= RST_VAL;
    else     stg[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= RST_VAL;
      else     stg[s] <= stg[s-1];
    end
  end

  assign q_o = stg[STAGES-1];

endmodule

// File: rtl/vxr_i2c_rx.sv
module vxr_i2c_rx
  import vxr_pkg::*;
#(
  parameter logic [7:0] ADDR_LO = 8'h86,
  parameter logic [7:0] ADDR_HI = 8'h06
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_s,
  input  logic       sda_s,
  input  logic       strap,
  output logic       sda_oe,
  output logic       byte_stb,
  output logic [7:0] byte_q
);

  localparam logic [3:0] ACK_SLOT = 4'd8;

  rx_state_t  state;
  logic [3:0] cnt;
  logic [7:0] shreg;
  logic       scl_q, sda_q;
  logic       scl_rise, scl_fall, start_det, stop_det;
  logic [7:0] my_addr;

  assign my_addr   = strap ? ADDR_HI : ADDR_LO;
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  assign byte_q    = shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= RX_IDLE;
      cnt      <= '0;
      shreg    <= '0;
      sda_oe   <= 1'b0;
      byte_stb <= 1'b0;
    end else begin
      byte_stb <= 1'b0;
      if (start_det) begin
        state  <= RX_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        state  <= RX_IDLE;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (state == RX_ADDR || state == RX_DATA) begin
        if (scl_rise) begin
          if (cnt != ACK_SLOT) begin
            shreg <= {shreg[6:0], sda_s};
            cnt   <= cnt + 4'd1;
          end else begin
            cnt <= '0;
            if (sda_oe && state == RX_DATA) byte_stb <= 1'b1;
            if (sda_oe && state == RX_ADDR) state <= RX_DATA;
          end
        end
        if (scl_fall) begin
          if (cnt == ACK_SLOT) begin
            if (state == RX_DATA || shreg == my_addr) sda_oe <= 1'b1;
            else                                       state  <= RX_SKIP;
          end else if (cnt == 4'd0) begin
            sda_oe <= 1'b0;
          end
        end
      end
    end
  end

  // R9
  ack_low_scl_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_s);

  // R2
  skip_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (state == RX_SKIP) |-> !sda_oe);

  // R10
  start_addr_chk: assert property (@(posedge clk) disable iff (rst)
    start_det |=> (state == RX_ADDR && cnt == 4'd0));

  // R8
  stb_in_ack_chk: assert property (@(posedge clk) disable iff (rst)
    byte_stb |-> sda_oe);

endmodule

// File: rtl/vxr_route_tbl.sv
module vxr_route_tbl
  import vxr_pkg::*;
#(
  parameter int N_OUT = 6,
  parameter int SEL_W = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_stb,
  input  logic [7:0]             wr_byte,
  output logic [N_OUT*SEL_W-1:0] sel_o,
  output logic [N_OUT-1:0]       valid_o
);

  dst_dec_t dec;
  assign dec = decode_dst(wr_byte[7:3]);

  for (genvar i = 0; i < N_OUT; i++) begin : g_dst
    logic hit_i;
    assign hit_i = wr_stb && dec.hit && (int'(dec.idx) == i);

    always_ff @(posedge clk) begin
      if (rst) begin
        sel_o[i*SEL_W +: SEL_W] <= '0;
        valid_o[i]              <= 1'b0;
      end else if (hit_i) begin
        sel_o[i*SEL_W +: SEL_W] <= wr_byte[SEL_W-1:0];
        valid_o[i]              <= 1'b1;
      end
    end

    // R6
    valid_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      valid_o[i] |=> valid_o[i]);
  end

  // R5
  sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_stb |=> $stable(sel_o) && $stable(valid_o));

  // R5
  one_new_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(valid_o & ~$past(valid_o)) <= 1);

endmodule

// File: rtl/vidx_route_ctrl.sv
module vidx_route_ctrl #(
  parameter int         N_IN        = 8,
  parameter int         N_OUT       = 6,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] ADDR_LO     = 8'h86,
  parameter logic [7:0] ADDR_HI     = 8'h06,
  localparam int        SEL_W       = $clog2(N_IN)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   scl_i,
  input  logic                   sda_i,
  input  logic                   strap_i,
  output logic                   sda_oe_o,
  output logic [N_OUT*SEL_W-1:0] sel_o,
  output logic [N_OUT-1:0]       valid_o
);

  logic [1:0] bus_s;
  logic       wr_stb;
  logic [7:0] wr_byte;

  vxr_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({scl_i, sda_i}),
    .q_o (bus_s)
  );

  vxr_i2c_rx #(.ADDR_LO(ADDR_LO), .ADDR_HI(ADDR_HI)) u_rx (
    .clk      (clk),
    .rst      (rst),
    .scl_s    (bus_s[1]),
    .sda_s    (bus_s[0]),
    .strap    (strap_i),
    .sda_oe   (sda_oe_o),
    .byte_stb (wr_stb),
    .byte_q   (wr_byte)
  );

  vxr_route_tbl #(.N_OUT(N_OUT), .SEL_W(SEL_W)) u_tbl (
    .clk     (clk),
    .rst     (rst),
    .wr_stb  (wr_stb),
    .wr_byte (wr_byte),
    .sel_o   (sel_o),
    .valid_o (valid_o)
  );

endmodule

// File: tb/sim_vidx_route_ctrl.sv
module sim_vidx_route_ctrl;

  localparam int H = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        scl = 1'b1;
  logic        sda_drv = 1'b1;
  logic        strap = 1'b0;
  logic        sda_oe;
  logic [17:0] sel;
  logic [5:0]  valid;
  logic        sda_line;

  assign sda_line = sda_drv & ~sda_oe;

  always #2.5 clk = ~clk;

  vidx_route_ctrl u0 (
    .clk      (clk),
    .rst      (rst),
    .scl_i    (scl),
    .sda_i    (sda_line),
    .strap_i  (strap),
    .sda_oe_o (sda_oe),
    .sel_o    (sel),
    .valid_o  (valid)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  logic [2:0] exp_sel [6];
  logic [5:0] exp_val;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  function automatic logic [4:0] dst_code(input int d);
    case (d)
      0: return 5'b00000;
      1: return 5'b00100;
      2: return 5'b00010;
      3: return 5'b00001;
      4: return 5'b00101;
      default: return 5'b00011;
    endcase
  endfunction

  function automatic void model_apply(input logic [7:0] b);
    for (int d = 0; d < 6; d++)
      if (dst_code(d) == b[7:3]) begin
        exp_sel[d] = b[2:0];
        exp_val[d] = 1'b1;
      end
  endfunction

  task automatic check_routes(input string req);
    logic [17:0] e;
    for (int d = 0; d < 6; d++) e[d*3 +: 3] = exp_sel[d];
    chk(valid == exp_val, req, int'(valid), int'(exp_val));
    for (int d = 0; d < 6; d++)
      if (exp_val[d]) chk(sel[d*3 +: 3] == e[d*3 +: 3], req, int'(sel[d*3 +: 3]), int'(e[d*3 +: 3]));
  endtask

  task automatic bus_start();
    sda_drv = 1'b1; tick(H);
    scl = 1'b1; tick(H);
    sda_drv = 1'b0; tick(H);
    scl = 1'b0; tick(4);
  endtask

  task automatic bus_stop();
    sda_drv = 1'b0; tick(H);
    scl = 1'b1; tick(H);
    sda_drv = 1'b1; tick(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack, output logic rel);
    for (int i = 7; i >= 0; i--) begin
      sda_drv = b[i]; tick(H);
      scl = 1'b1; tick(H);
      scl = 1'b0; tick(4);
    end
    sda_drv = 1'b1; tick(H);
    scl = 1'b1; tick(H/2);
    ack = sda_oe;
    tick(H/2);
    scl = 1'b0; tick(8);
    rel = !sda_oe;
  endtask

  task automatic txn(input logic [7:0] a, input logic [7:0] b,
                     input bit ea, input bit eb, input string req);
    logic ack, rel;
    bus_start();
    send_byte(a, ack, rel);
    chk(ack == ea, req, int'(ack), int'(ea));
    chk(rel, "R9", int'(sda_oe), 0);
    send_byte(b, ack, rel);
    chk(ack == eb, req, int'(ack), int'(eb));
    if (eb) model_apply(b);
    check_routes(req);
    bus_stop();
  endtask

  initial begin
    logic ack, rel;
    exp_val = '0;
    for (int d = 0; d < 6; d++) exp_sel[d] = '0;
    tick(5);
    rst = 1'b0;
    tick(2);
    // R1 reset state
    chk(valid == 6'b0, "R1", int'(valid), 0);
    chk(sda_oe == 1'b0, "R1", int'(sda_oe), 0);

    // R3 worked example byte 0x25
    txn(8'h86, 8'h25, 1, 1, "R3");
    chk(sel[5:3] == 3'd5 && valid == 6'b000010, "R3", int'(sel[5:3]), 5);

    // R4 R5 R6 sweep every destination and source with strap 0
    for (int d = 0; d < 6; d++)
      for (int s = 0; s < 8; s++)
        txn(8'h86, {dst_code(d), 3'(s)}, 1, 1, "R4");

    // R7 unused destination codes
    txn(8'h86, {5'b00110, 3'd2}, 1, 1, "R7");
    txn(8'h86, {5'b00111, 3'd6}, 1, 1, "R7");
    txn(8'h86, {5'b01000, 3'd1}, 1, 1, "R7");
    txn(8'h86, {5'b11111, 3'd3}, 1, 1, "R7");

    // R2 address filtering
    txn(8'h06, {dst_code(0), 3'd3}, 0, 0, "R2");
    txn(8'h87, {dst_code(1), 3'd2}, 0, 0, "R2");
    strap = 1'b1; tick(H);
    txn(8'h86, {dst_code(2), 3'd4}, 0, 0, "R2");
    for (int d = 0; d < 6; d++)
      txn(8'h06, {dst_code(d), 3'(7 - d)}, 1, 1, "R2");

    // R8 several routing bytes, applied at each acknowledge
    bus_start();
    send_byte(8'h06, ack, rel);
    chk(ack, "R8", int'(ack), 1);
    send_byte({dst_code(2), 3'd1}, ack, rel);
    chk(ack && sel[8:6] == 3'd1, "R8", int'(sel[8:6]), 1);
    send_byte({dst_code(2), 3'd6}, ack, rel);
    chk(ack && sel[8:6] == 3'd6, "R8", int'(sel[8:6]), 6);
    send_byte({dst_code(5), 3'd0}, ack, rel);
    chk(ack && sel[17:15] == 3'd0, "R8", int'(sel[17:15]), 0);
    chk(rel, "R9", int'(sda_oe), 0);
    bus_stop();
    model_apply({dst_code(2), 3'd6});
    model_apply({dst_code(5), 3'd0});
    check_routes("R8");

    // R10 START partway through a byte restarts address reception
    bus_start();
    for (int i = 0; i < 3; i++) begin
      sda_drv = 1'b1; tick(H);
      scl = 1'b1; tick(H);
      scl = 1'b0; tick(4);
    end
    bus_start();
    send_byte(8'h06, ack, rel);
    chk(ack, "R10", int'(ack), 1);
    send_byte({dst_code(3), 3'd4}, ack, rel);
    chk(ack, "R10", int'(ack), 1);
    model_apply({dst_code(3), 3'd4});
    // repeated START after a data byte, before any STOP
    bus_start();
    send_byte(8'h06, ack, rel);
    chk(ack, "R10", int'(ack), 1);
    send_byte({dst_code(4), 3'd2}, ack, rel);
    chk(ack, "R10", int'(ack), 1);
    model_apply({dst_code(4), 3'd2});
    bus_stop();
    check_routes("R10");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule